// File: doc/BRIEF.md
# Interrupt Status and Mask Bank

This block gathers single-cycle event pulses from a serial bus controller into a sticky status register and turns them into one level-sensitive interrupt line. Each event source has one bit. Software clears status bits by writing ones to them. A bit whose event pulses while its clear is being written stays set, so an event that lands during the clear is not lost.

Each bit has its own mask. Software never writes the mask directly. It uses two write-only strobe registers: writing ones to the unmask register lets those sources through, and writing ones to the mask register blocks them. The mask that results can be read at its own offset. The status register, the mask readback and both strobe registers use the same ten-bit layout:

| Bit | Event |
|-----|-------|
| 0 | transfer done |
| 1 | FIFO threshold |
| 2 | no acknowledge |
| 3 | timeout |
| 4 | target ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 9 | arbitration lost |

Bit 8 is not implemented.

Register access uses a valid/ready request channel and a valid/ready read-response channel.
- A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high.
- A write produces no response.
- An accepted read presents its data on the response channel one cycle later. The data holds until `rsp_ready_i` is high.
- While a response waits, no further request is accepted.

Top module: `irq_event_bank`

## Requirements
- R1: An event pulse on an implemented bit sets that status bit at the clock edge that samples it, and the bit stays set until it is cleared.
- R2: A write to offset 0x10 clears every status bit written as 1. Bits written as 0 keep their value.
- R3: When an event pulse and a clear of the same status bit land in the same cycle, the bit ends up set.
- R4: A write to offset 0x24 clears the mask bits written as 1, which unmasks those sources. Bits written as 0 are unchanged.
- R5: A write to offset 0x28 sets the mask bits written as 1, which masks those sources. Bits written as 0 are unchanged.
- R6: Offset 0x20 reads the current mask. A set bit means masked. After reset the mask reads 0x2FF.
- R7: Offsets 0x24 and 0x28 read as zero. Writes to 0x20 and to unmapped offsets change no state. Reads of unmapped offsets return zero.
- R8: Bit 8 and bits 10 and up read as zero in status and mask, and writes and events on those bits are ignored.
- R9: `irq_o` is high exactly one cycle after the status and mask registers hold a set, unmasked bit, and is low otherwise.
- R10: Read data appears on the response channel the cycle after the request is accepted. While `rsp_ready_i` is low the data stays stable and `req_ready_o` is low.
- R11: After reset, status reads zero, `irq_o` is low and no response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Single-cycle event pulses, one per status bit |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_rdata_o | output | 32 | Read response data |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Status or mask state that goes wrong inside the block shows up on `irq_o` in the next cycle, provided the affected bit is unmasked and set. Otherwise it stays hidden until one of the two readable offsets is read. For this reason the bench reads both registers after every kind of stimulus. A behavioural model runs alongside and compares the interrupt line, the handshake signals and the returned data on every clock. A fault in response holding or back-pressure therefore shows up in the first cycle where `rsp_ready_i` is low.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned EVT_W = 10;
  // implemented bits: 0..7 and 9
  localparam logic [EVT_W-1:0] IMPL_BITS = 10'h2FF;

  localparam int unsigned EV_DONE      = 0;
  localparam int unsigned EV_THRESH    = 1;
  localparam int unsigned EV_NOACK     = 2;
  localparam int unsigned EV_TIMEOUT   = 3;
  localparam int unsigned EV_TGT_RDY   = 4;
  localparam int unsigned EV_RX_OVF    = 5;
  localparam int unsigned EV_TX_OVF    = 6;
  localparam int unsigned EV_RX_UNF    = 7;
  localparam int unsigned EV_ARB_LOSS  = 9;

  localparam logic [7:0] OFS_STATUS  = 8'h10;
  localparam logic [7:0] OFS_MASK    = 8'h20;
  localparam logic [7:0] OFS_UNMASK  = 8'h24;
  localparam logic [7:0] OFS_DOMASK  = 8'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_UNMASK,
    SEL_DOMASK
  } reg_sel_e;
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_valid_i,
  input  logic              req_ready_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              wr_status_o,
  output logic              wr_unmask_o,
  output logic              wr_domask_o,
  output logic              rd_fire_o,
  output irqb_pkg::reg_sel_e rd_sel_o
);
  import irqb_pkg::*;

  logic     fire;
  reg_sel_e sel;

  assign fire = req_valid_i & req_ready_i;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr_i == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (req_addr_i == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
    else if (req_addr_i == ADDR_W'(OFS_UNMASK)) sel = SEL_UNMASK;
    else if (req_addr_i == ADDR_W'(OFS_DOMASK)) sel = SEL_DOMASK;
  end

  assign wr_status_o = fire & req_write_i & (sel == SEL_STATUS);
  assign wr_unmask_o = fire & req_write_i & (sel == SEL_UNMASK);
  assign wr_domask_o = fire & req_write_i & (sel == SEL_DOMASK);
  assign rd_fire_o   = fire & ~req_write_i;
  assign rd_sel_o    = sel;
endmodule

// File: rtl/irqb_status.sv
module irqb_status #(
  parameter int unsigned     EVT_W = 10,
  parameter logic [EVT_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [EVT_W-1:0] clr_bits_i,
  output logic [EVT_W-1:0] status_o
);
  logic [EVT_W-1:0] unused_in;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bit_q <= 1'b0;
        else if (evt_i[i])                   bit_q <= 1'b1;
        else if (clr_en_i && clr_bits_i[i])  bit_q <= 1'b0;
      end
      assign status_o[i]  = bit_q;
      assign unused_in[i] = 1'b0;
    end else begin : g_hole
      assign status_o[i]  = 1'b0;
      assign unused_in[i] = evt_i[i] ^ clr_bits_i[i];
    end
  end

  // R1 R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & IMPL) != '0) |=> ((status_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((status_o & $past(clr_bits_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
  parameter int unsigned     EVT_W = 10,
  parameter logic [EVT_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unmask_en_i,
  input  logic             domask_en_i,
  input  logic [EVT_W-1:0] bits_i,
  output logic [EVT_W-1:0] mask_o
);
  logic [EVT_W-1:0] unused_in;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic m_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          m_q <= 1'b1;
        else if (domask_en_i && bits_i[i])   m_q <= 1'b1;
        else if (unmask_en_i && bits_i[i])   m_q <= 1'b0;
      end
      assign mask_o[i]    = m_q;
      assign unused_in[i] = 1'b0;
    end else begin : g_hole
      assign mask_o[i]    = 1'b0;
      assign unused_in[i] = bits_i[i];
    end
  end

  // R4
  unmask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_en_i && !domask_en_i) |=> ((mask_o & $past(bits_i)) == '0));

  // R5
  domask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    domask_en_i |=> ((mask_o & $past(bits_i & IMPL)) == $past(bits_i & IMPL)));
endmodule

// File: rtl/irqb_rsp.sv
module irqb_rsp #(
  parameter int unsigned EVT_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire_i,
  input  irqb_pkg::reg_sel_e rd_sel_i,
  input  logic [EVT_W-1:0]   status_i,
  input  logic [EVT_W-1:0]   mask_i,
  input  logic               rsp_ready_i,
  output logic               req_ready_o,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o
);
  import irqb_pkg::*;

  localparam int unsigned PAD_W = DATA_W - EVT_W;

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [EVT_W-1:0]  pick;

  always_comb begin
    case (rd_sel_i)
      SEL_STATUS: pick = status_i;
      SEL_MASK:   pick = mask_i;
      default:    pick = '0;
    endcase
  end

  assign req_ready_o = ~valid_q | rsp_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (rd_fire_i) begin
      valid_q <= 1'b1;
      data_q  <= {{PAD_W{1'b0}}, pick};
    end else if (rsp_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_rdata_o = data_q;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rsp_ready_i) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [irqb_pkg::EVT_W-1:0] evt_i,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  output logic                       rsp_valid_o,
  input  logic                       rsp_ready_i,
  output logic [DATA_W-1:0]          rsp_rdata_o,
  output logic                       irq_o
);
  import irqb_pkg::*;

  localparam int unsigned EW = EVT_W;

  logic          wr_status, wr_unmask, wr_domask, rd_fire;
  reg_sel_e      rd_sel;
  logic [EW-1:0] status, mask, wbits;
  logic          unused_hi;
  logic          irq_q;

  assign wbits     = req_wdata_i[EW-1:0];
  assign unused_hi = ^req_wdata_i[DATA_W-1:EW];

  irqb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid_i (req_valid_i),
    .req_ready_i (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .wr_status_o (wr_status),
    .wr_unmask_o (wr_unmask),
    .wr_domask_o (wr_domask),
    .rd_fire_o   (rd_fire),
    .rd_sel_o    (rd_sel)
  );

  irqb_status #(.EVT_W(EW), .IMPL(IMPL_BITS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_en_i   (wr_status),
    .clr_bits_i (wbits),
    .status_o   (status)
  );

  irqb_mask #(.EVT_W(EW), .IMPL(IMPL_BITS)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .unmask_en_i (wr_unmask),
    .domask_en_i (wr_domask),
    .bits_i      (wbits),
    .mask_o      (mask)
  );

  irqb_rsp #(.EVT_W(EW), .DATA_W(DATA_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire_i   (rd_fire),
    .rd_sel_i    (rd_sel),
    .status_i    (status),
    .mask_i      (mask),
    .rsp_ready_i (rsp_ready_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & ~mask);
  end
  assign irq_o = irq_q;

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq_o);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == IMPL_BITS) |=> !irq_o);

  // R10
  bp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready_o |-> (rsp_valid_o && !rsp_ready_i));
endmodule

// File: tb/irq_event_bank_tb.sv
`timescale 1ns/1ps
module irq_event_bank_tb;
  localparam logic [9:0] IMPLM = 10'b10_1111_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_event_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [9:0]  m_stat, m_mask, m_wb, m_ns, m_nm;
  logic        m_irq, m_rv, m_fire;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = IMPLM; m_irq = 1'b0; m_rv = 1'b0; m_rd = '0;
    end else begin
      m_fire = req_valid && (!m_rv || rsp_ready);
      m_wb   = req_wdata[9:0] & IMPLM;
      m_ns   = m_stat;
      m_nm   = m_mask;
      m_irq  = |(m_stat & ~m_mask);
      if (m_fire && req_write) begin
        if (req_addr == 8'h10) m_ns = m_ns & ~m_wb;
        if (req_addr == 8'h24) m_nm = m_nm & ~m_wb;
        if (req_addr == 8'h28) m_nm = m_nm | m_wb;
      end
      if (m_fire && !req_write) begin
        m_rv = 1'b1;
        if (req_addr == 8'h10)      m_rd = {22'd0, m_stat};
        else if (req_addr == 8'h20) m_rd = {22'd0, m_mask};
        else                        m_rd = '0;
      end else if (rsp_ready) begin
        m_rv = 1'b0;
      end
      m_stat = m_ns | (evt & IMPLM);
      m_mask = m_nm;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R10 req_ready vs model", {31'd0, req_ready}, {31'd0, (!m_rv || rsp_ready)});
      check("R10 rsp_valid vs model", {31'd0, rsp_valid}, {31'd0, m_rv});
      if (m_rv) check("R10 rsp_rdata vs model", rsp_rdata, m_rd);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [9:0] b);
    @(negedge clk); evt = b;
    @(negedge clk); evt = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    check("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    bus_read(8'h10, d); check("R11 status after reset", d, 32'h0);
    bus_read(8'h20, d); check("R6 mask after reset", d, 32'h2FF);

    // R1 sticky set, masked so no irq
    pulse(10'h001);
    idle(3);
    bus_read(8'h10, d); check("R1 status sticky", d, 32'h001);
    check("R9 masked source no irq", {31'd0, irq}, 32'd0);

    // R4 unmask
    bus_write(8'h24, 32'h001);
    bus_read(8'h20, d); check("R4 unmask bit0", d, 32'h2FE);
    idle(2);
    check("R9 irq with unmasked set bit", {31'd0, irq}, 32'd1);

    // R2 write-one-to-clear
    bus_write(8'h10, 32'h000);
    bus_read(8'h10, d); check("R2 zero write keeps bits", d, 32'h001);
    bus_write(8'h10, 32'h001);
    bus_read(8'h10, d); check("R2 one write clears", d, 32'h000);
    idle(2);
    check("R9 irq low after clear", {31'd0, irq}, 32'd0);

    // R8 unimplemented bit ignores events
    pulse(10'h3FF);
    bus_read(8'h10, d); check("R8 status holes read zero", d, 32'h2FF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, d); check("R2 clear all", d, 32'h000);

    // R3 event wins against simultaneous clear
    pulse(10'h008);
    @(negedge clk);
    evt = 10'h008; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 32'h008;
    @(negedge clk);
    evt = '0; req_valid = 1'b0; req_write = 1'b0;
    bus_read(8'h10, d); check("R3 event beats clear", d, 32'h008);
    bus_write(8'h10, 32'h008);

    // R5 mask again, R8 upper strobe bits
    bus_write(8'h28, 32'h001);
    bus_read(8'h20, d); check("R5 domask bit0", d, 32'h2FF);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read(8'h20, d); check("R8 unmask all reads implemented only", d, 32'h000);
    bus_write(8'h28, 32'h0000_0500);
    bus_read(8'h20, d); check("R8 hole bit8 ignored, bit10 ignored", d, 32'h000);

    // R7 write-only and unmapped
    bus_read(8'h24, d); check("R7 unmask reads zero", d, 32'h0);
    bus_read(8'h28, d); check("R7 domask reads zero", d, 32'h0);
    bus_write(8'h20, 32'h3FF);
    bus_write(8'h14, 32'h3FF);
    bus_read(8'h20, d); check("R7 mask offset ignores write", d, 32'h000);
    bus_read(8'h10, d); check("R7 unmapped write no effect", d, 32'h000);
    bus_read(8'h30, d); check("R7 unmapped read zero", d, 32'h0);

    // R9 latency
    idle(2);
    @(negedge clk); evt = 10'h010;
    @(negedge clk); evt = '0;
    check("R9 irq not yet high", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R9 irq high one cycle after status", {31'd0, irq}, 32'd1);

    // R10 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(negedge clk);
    req_addr = 8'h20;
    check("R10 response valid", {31'd0, rsp_valid}, 32'd1);
    check("R10 req_ready low while pending", {31'd0, req_ready}, 32'd0);
    check("R10 status data", rsp_rdata, 32'h010);
    idle(3);
    check("R10 data held", rsp_rdata, 32'h010);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 queued read of mask", rsp_rdata, 32'h000);
    idle(3);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule